// File: doc/BRIEF.md
# Melody Sequencer with Square-Wave Tone Generator

This block plays short tunes held as note words in an 80-entry melody memory that is fixed at build time. Each note word carries a 4-bit pitch index into a 16-entry divider table, a 3-bit length code and an end-of-tune flag. Pitch index 0 is a rest. A tone divider running from the 32.768 kHz clock toggles a square wave. The wave is driven on a true output and on an inverted output. Both outputs stay low during a rest or while the block is idle.

Software starts a tune by writing its start address. It picks one of two build-time tempos and a speed multiplier of 1, 8, 16 or 32. It can also arm repeat mode with a restart address. A new start write made during playback drops the current tune in the same cycle. Every completed tune sets a sticky interrupt flag, and software clears the flag by writing 1.

Top module: `melody_seq`

## Requirements
- R1: After reset `busy`, `irq`, `toneOut` and `toneOutN` are all 0.
- R2: The melody word at address a (0..79) has pitch index a mod 16, length code a div 16 and end flag set when a mod 5 equals 4. Tunes therefore span five addresses, for example 5..9.
- R3: A note lasts (length code + 1) × P clock cycles, where P = 491520 / (T × M). T is TEMPO_A (default 120) when `tempoSel` is 0 and TEMPO_B (default 240) when it is 1. M is 1, 8, 16 or 32 for `multSel` 0, 1, 2 or 3. The tempo and multiplier are sampled when each note is loaded.
- R4: With LOW_RANGE = 0, pitch indices 1..15 give half periods of 63, 59, 56, 53, 50, 47, 44, 42, 39, 37, 35, 33, 31, 30 and 28 cycles. LOW_RANGE = 1 doubles each value. `toneOut` is high for the first half period of a note.
- R5: While a pitched note sounds, `toneOutN` is the complement of `toneOut`. During a rest (index 0) and while idle, both outputs are 0.
- R6: After the note that carries the end flag, playback stops and `busy` falls unless repeat applies. `irq` is set on the same edge.
- R7: `irq` stays 1 until a cycle with `irqClr` = 1 clears it.
- R8: When `repeatEn` is 1 at the end of a tune, playback continues at `repeatAddr` with no gap, and `irq` is still set for the finished pass.
- R9: A `startWr` with a valid address during playback loads the new tune's first note on the next edge. The old tune's remaining notes are dropped.
- R10: A `startWr` with an address of 80 or more is ignored, whether the block is idle or playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timing clock |
| rstN | input | 1 | synchronous reset, active low |
| startWr | input | 1 | start-address write strobe |
| startAddr | input | 7 | first note address of the tune |
| repeatEn | input | 1 | repeat mode enable |
| repeatAddr | input | 7 | address to resume at when a tune ends in repeat mode |
| tempoSel | input | 1 | picks TEMPO_A (0) or TEMPO_B (1) |
| multSel | input | 2 | tempo multiplier ×1, ×8, ×16, ×32 |
| irqClr | input | 1 | write 1 to clear the completion flag |
| toneOut | output | 1 | melody square wave |
| toneOutN | output | 1 | inverted melody square wave |
| busy | output | 1 | a tune is playing |
| irq | output | 1 | tune-completion interrupt request |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- The two tone outputs are never high together, and both stay low while idle.
- The completion flag never drops without a clear.
- A completion always raises the flag.
- An out-of-range start never wakes the block.
- The playing address and the tone counter stay inside their ranges.

The exact half periods, note lengths under each tempo and multiplier, rest silence, the seamless hand-over in repeat mode and the cut-over timing of a forced tune change depend on multi-note sequences. Only the directed bench scenarios show these, by counting cycles at the ports.

// File: rtl/melody_seq_pkg.sv
package melody_seq_pkg;

  typedef struct packed {
    logic loadNote;
    logic stopPlay;
    logic running;
  } seqStrobe_t;

  typedef struct packed {
    logic       endFlag;
    logic [2:0] lenCode;
    logic [3:0] toneIdx;
  } noteWord_t;

  // Build-time melody contents, computed from the address.
  function automatic noteWord_t romWord(input int unsigned addr);
    noteWord_t w;
    w.toneIdx = 4'(addr % 16);
    w.lenCode = 3'((addr / 16) % 8);
    w.endFlag = ((addr % 5) == 4);
    return w;
  endfunction

  // Half-period in clock cycles; index 0 is a rest.
  function automatic logic [15:0] halfPeriod(input logic [3:0] idx, input bit lowRange);
    logic [15:0] v;
    case (idx)
      4'd1:  v = 16'd63;
      4'd2:  v = 16'd59;
      4'd3:  v = 16'd56;
      4'd4:  v = 16'd53;
      4'd5:  v = 16'd50;
      4'd6:  v = 16'd47;
      4'd7:  v = 16'd44;
      4'd8:  v = 16'd42;
      4'd9:  v = 16'd39;
      4'd10: v = 16'd37;
      4'd11: v = 16'd35;
      4'd12: v = 16'd33;
      4'd13: v = 16'd31;
      4'd14: v = 16'd30;
      4'd15: v = 16'd28;
      default: v = 16'd1;
    endcase
    return lowRange ? (v << 1) : v;
  endfunction

endpackage

// File: rtl/melody_seq_ctrl.sv
module melody_seq_ctrl
  import melody_seq_pkg::*;
#(
  parameter int MEM_DEPTH = 80,
  parameter int ADDR_W    = 7,
  parameter int DUR_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] repeatAddr,
  input  logic              irqClr,
  input  logic              curEnd,
  input  logic [DUR_W-1:0]  nextDur,
  output seqStrobe_t        strobe,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              busy,
  output logic              irq
);

  logic [DUR_W-1:0] noteCnt;
  logic validStart, repeatOk, noteDone, tuneDone;
  logic [ADDR_W-1:0] seqAddr;

  always_comb begin
    validStart = startWr && (int'(startAddr) < MEM_DEPTH);
    repeatOk   = repeatEn && (int'(repeatAddr) < MEM_DEPTH);
    noteDone   = busy && (noteCnt == '0);
    tuneDone   = noteDone && curEnd;
    seqAddr    = (int'(curAddr) == MEM_DEPTH - 1) ? '0 : curAddr + 1'b1;
    if (validStart)  fetchAddr = startAddr;
    else if (curEnd) fetchAddr = repeatAddr;
    else             fetchAddr = seqAddr;
    strobe.loadNote = validStart || (noteDone && (!curEnd || repeatOk));
    strobe.stopPlay = tuneDone && !repeatOk && !validStart;
    strobe.running  = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curAddr <= '0;
      noteCnt <= '0;
    end else if (strobe.loadNote) begin
      busy    <= 1'b1;
      curAddr <= fetchAddr;
      noteCnt <= nextDur - 1'b1;
    end else if (strobe.stopPlay) begin
      busy    <= 1'b0;
    end else if (busy) begin
      noteCnt <= noteCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         irq <= 1'b0;
    else if (tuneDone) irq <= 1'b1;
    else if (irqClr)   irq <= 1'b0;
  end

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqClr |=> irq);
  assert_end_sets_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> int'(curAddr) < MEM_DEPTH);
  assert_bad_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startWr && int'(startAddr) >= MEM_DEPTH |=> !busy);

endmodule

// File: rtl/melody_seq_dp.sv
module melody_seq_dp
  import melody_seq_pkg::*;
#(
  parameter int CLK_HZ    = 32768,
  parameter int TEMPO_A   = 120,
  parameter int TEMPO_B   = 240,
  parameter bit LOW_RANGE = 1'b0,
  parameter int ADDR_W    = 7,
  parameter int DUR_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              tempoSel,
  input  logic [1:0]        multSel,
  output logic              curEnd,
  output logic [DUR_W-1:0]  nextDur,
  output logic              toneOut,
  output logic              toneOutN
);

  localparam int SIXTEENTH_BASE = CLK_HZ * 15;

  function automatic int multOf(input int sel);
    return (sel == 0) ? 1 : (4 << sel);
  endfunction

  logic [DUR_W-1:0] periodTab [8];

  for (genvar t = 0; t < 2; t++) begin : g_tempo
    for (genvar m = 0; m < 4; m++) begin : g_mult
      localparam int TEMPO = (t == 0) ? TEMPO_A : TEMPO_B;
      assign periodTab[t*4+m] = DUR_W'(SIXTEENTH_BASE / (TEMPO * multOf(m)));
    end
  end

  noteWord_t curWord, nextWord;
  logic [DUR_W-1:0] lenPlus, period;
  logic [3:0]  toneIdx;
  logic [15:0] toneCnt, curDiv;
  logic        phase, sounding;

  always_comb begin
    curWord  = romWord(int'(curAddr));
    nextWord = romWord(int'(fetchAddr));
    curEnd   = curWord.endFlag;
    period   = periodTab[{tempoSel, multSel}];
    lenPlus  = DUR_W'(nextWord.lenCode) + DUR_W'(1);
    nextDur  = DUR_W'(lenPlus * period);
    curDiv   = halfPeriod(toneIdx, LOW_RANGE);
    sounding = strobe.running && (toneIdx != 4'd0);
    toneOut  = sounding && phase;
    toneOutN = sounding && !phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toneIdx <= '0;
      toneCnt <= '0;
      phase   <= 1'b0;
    end else if (strobe.loadNote) begin
      toneIdx <= nextWord.toneIdx;
      toneCnt <= halfPeriod(nextWord.toneIdx, LOW_RANGE) - 1'b1;
      phase   <= 1'b1;
    end else if (strobe.stopPlay) begin
      toneIdx <= '0;
      phase   <= 1'b0;
    end else if (sounding) begin
      if (toneCnt == '0) begin
        toneCnt <= curDiv - 1'b1;
        phase   <= !phase;
      end else begin
        toneCnt <= toneCnt - 1'b1;
      end
    end
  end

  assert_tone_count_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    sounding |-> toneCnt < curDiv);

endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import melody_seq_pkg::*;
#(
  parameter int CLK_HZ    = 32768,
  parameter int MEM_DEPTH = 80,
  parameter int TEMPO_A   = 120,
  parameter int TEMPO_B   = 240,
  parameter bit LOW_RANGE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic [6:0] startAddr,
  input  logic       repeatEn,
  input  logic [6:0] repeatAddr,
  input  logic       tempoSel,
  input  logic [1:0] multSel,
  input  logic       irqClr,
  output logic       toneOut,
  output logic       toneOutN,
  output logic       busy,
  output logic       irq
);

  localparam int ADDR_W    = 7;
  localparam int MIN_TEMPO = (TEMPO_A < TEMPO_B) ? TEMPO_A : TEMPO_B;
  localparam int MAX_DUR   = 8 * ((CLK_HZ * 15) / MIN_TEMPO);
  localparam int DUR_W     = $clog2(MAX_DUR + 1);

  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] curAddr, fetchAddr;
  logic              curEnd;
  logic [DUR_W-1:0]  nextDur;

  melody_seq_ctrl #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W), .DUR_W(DUR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startAddr(startAddr),
    .repeatEn(repeatEn), .repeatAddr(repeatAddr), .irqClr(irqClr),
    .curEnd(curEnd), .nextDur(nextDur), .strobe(strobe), .curAddr(curAddr),
    .fetchAddr(fetchAddr), .busy(busy), .irq(irq)
  );

  melody_seq_dp #(.CLK_HZ(CLK_HZ), .TEMPO_A(TEMPO_A), .TEMPO_B(TEMPO_B),
                  .LOW_RANGE(LOW_RANGE), .ADDR_W(ADDR_W), .DUR_W(DUR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curAddr(curAddr),
    .fetchAddr(fetchAddr), .tempoSel(tempoSel), .multSel(multSel),
    .curEnd(curEnd), .nextDur(nextDur), .toneOut(toneOut), .toneOutN(toneOutN)
  );

  assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(toneOut && toneOutN));
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !toneOut && !toneOutN);

endmodule

// File: tb/melody_seq_tb.sv
module melody_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startWr = 1'b0, repeatEn = 1'b0, tempoSel = 1'b0, irqClr = 1'b0;
  logic [6:0] startAddr = '0, repeatAddr = '0;
  logic [1:0] multSel = 2'd3;
  logic toneOut, toneOutN, busy, irq;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  melody_seq u_dut (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startAddr(startAddr),
    .repeatEn(repeatEn), .repeatAddr(repeatAddr), .tempoSel(tempoSel),
    .multSel(multSel), .irqClr(irqClr), .toneOut(toneOut), .toneOutN(toneOutN),
    .busy(busy), .irq(irq)
  );

  function automatic int halfOf(input int idx);
    int tab[16] = '{1, 63, 59, 56, 53, 50, 47, 44, 42, 39, 37, 35, 33, 31, 30, 28};
    return tab[idx];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startTune(input int a);
    @(negedge clk);
    startWr = 1'b1; startAddr = 7'(a);
    @(negedge clk);
    startWr = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  // Counts busy samples; optionally writes pokeAddr at sample pokeAt.
  task automatic countBusy(input int pokeAt, input int pokeAddr, output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      if (n == pokeAt) begin startWr = 1'b1; startAddr = 7'(pokeAddr); end
      else startWr = 1'b0;
      @(negedge clk);
    end
    startWr = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    countBusy(0, 0, n);
  endtask

  task automatic testReset();
    check(busy == 0, "R1 busy", busy, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(toneOut == 0, "R1 toneOut", toneOut, 0);
    check(toneOutN == 0, "R1 toneOutN", toneOutN, 0);
  endtask

  task automatic testPitch(input int a);
    int hi = 0, lo = 0;
    startTune(a);
    while (toneOut && hi < 1000) begin
      if (toneOutN) check(0, "R5 complement", 1, 0);
      hi++; @(negedge clk);
    end
    while (toneOutN && lo < 1000) begin
      if (toneOut) check(0, "R5 complement", 1, 0);
      lo++; @(negedge clk);
    end
    check(hi == halfOf(a % 16), "R4 high half", hi, halfOf(a % 16));
    check(lo == halfOf(a % 16), "R4 low half R5", lo, halfOf(a % 16));
    waitIdle();
    clearIrq();
  endtask

  task automatic testTune(input int tsel, input int msel, input int p);
    int n;
    tempoSel = tsel[0]; multSel = 2'(msel);
    startTune(5);
    countBusy(0, 0, n);
    check(n == 5 * p, "R3 R6 tune length", n, 5 * p);
    check(irq == 1, "R6 irq on end", irq, 1);
    clearIrq();
    check(irq == 0, "R7 irq clear", irq, 0);
    tempoSel = 1'b0; multSel = 2'd3;
  endtask

  task automatic testPause();
    // Tune 15..19: address 16 is a rest lasting 2P.
    startTune(15);
    repeat (128 + 4) @(negedge clk);
    check(busy == 1, "R5 busy in rest", busy, 1);
    check(toneOut == 0 && toneOutN == 0, "R5 rest silent", {toneOut, toneOutN}, 0);
    waitIdle();
    clearIrq();
  endtask

  task automatic testRepeat();
    int n = 0;
    repeatEn = 1'b1; repeatAddr = 7'd0;
    startTune(5);
    repeat (640) @(negedge clk);
    n = 640;
    check(busy == 1, "R8 continues", busy, 1);
    check(irq == 1, "R8 irq per pass", irq, 1);
    clearIrq();
    n += 2;
    repeatEn = 1'b0;
    while (busy && n < 10000) begin n++; @(negedge clk); end
    check(n == 1280, "R8 second pass length", n, 1280);
    check(irq == 1, "R6 irq after repeat", irq, 1);
    clearIrq();
  endtask

  task automatic testForced();
    int n;
    startTune(5);
    countBusy(100, 40, n);
    check(n == 100 + 15 * 128, "R9 forced change", n, 100 + 15 * 128);
    clearIrq();
  endtask

  task automatic testIgnored();
    int n;
    startTune(85);
    check(busy == 0, "R10 idle start ignored", busy, 0);
    startTune(5);
    countBusy(10, 90, n);
    check(n == 640, "R10 busy start ignored", n, 640);
    clearIrq();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPitch(1);
    testPitch(13);
    testPitch(7);
    testTune(0, 3, 128);
    testTune(1, 3, 64);
    testTune(0, 2, 256);
    testTune(0, 1, 512);
    testTune(0, 0, 4096);
    testPause();
    testRepeat();
    testForced();
    testIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule